// File: doc/BRIEF.md
# Serial Character Transmitter with Runtime Parity Selection

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A producer offers a character with a valid/ready handshake. The transmitter accepts it, then drives a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. After that it returns to the high idle level and is ready for the next character.

Bit timing comes from an external enable pulse, `tick_i`, which runs at sixteen times the bit rate. Each frame bit is held for `OS_RATE` such pulses. A 3-bit mode input selects how the parity slot behaves: computed even parity, computed odd parity, a constant one, a constant zero, or no parity slot at all. The mode and the data are both latched when the character is accepted, so the inputs may change freely while a frame is on the line.

Top module: `uart_par_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, tx_o is 1 and ready_o is 1.
- R2: A character is accepted on a rising clock edge where valid_i and ready_o are both 1. From the next cycle tx_o is 0 (the start bit) and ready_o is 0. ready_o stays 0 for the whole frame.
- R3: Every frame bit lasts exactly OS_RATE (default 16) tick_i pulses counted after acceptance. The frame order is start (0), data bit 0 up to data bit DATA_W-1, then the parity slot if present, then stop (1).
- R4: Mode code 3'b000 (even): the parity bit is the XOR of the data bits, so character 0x41 gives 0.
- R5: Mode code 3'b001 (odd): the parity bit is the inverted XOR of the data bits, so character 0x41 gives 1.
- R6: Mode code 3'b010 (mark): the parity bit is 1 for any data.
- R7: Mode code 3'b011 (space): the parity bit is 0 for any data.
- R8: Mode code 3'b100, and the unused codes 3'b101 to 3'b111, send no parity slot. The stop bit follows the last data bit directly.
- R9: data_i and mode_i are captured at acceptance. Changing them, or raising valid_i, while a frame is in progress has no effect on that frame.
- R10: ready_o returns to 1 in the cycle after the clock edge that carries the stop bit's last tick. A new character offered then starts its start bit at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Character to send |
| valid_i | input | 1 | Character on data_i is offered |
| ready_o | output | 1 | Transmitter can accept a character |
| mode_i | input | 3 | Parity mode code |
| tick_i | input | 1 | Oversampling enable, OS_RATE pulses per bit |
| tx_o | output | 1 | Serial line, idles high |

## Verification
The bench samples the line at the middle of every bit slot and compares the whole frame against a frame it builds itself.

- **Parity modes.** Character 0x41 is sent in all four parity modes. A design with even and odd swapped, or with constant parity tied to the wrong level, shows the wrong value in the parity slot.
- **No-parity codes.** Code 4 and an unused code are sent with no parity slot. A design that still inserts a slot puts an extra bit before the stop bit, and the high level then shows up late.
- **Mid-frame input changes.** The mode and the data are changed, and valid_i is raised, during a frame. A design that reads its inputs live corrupts the data bits or the parity bit, or restarts the frame.
- **Frame end.** ready_o is probed one tick before and right after the stop bit's final tick, and a second character is then sent back to back. This catches a stop bit that is one tick short or long, or a lost cycle between frames.

// File: rtl/uart_par_tx_pkg.sv
package uart_par_tx_pkg;

  localparam logic [2:0] PM_EVEN  = 3'd0;
  localparam logic [2:0] PM_ODD   = 3'd1;
  localparam logic [2:0] PM_MARK  = 3'd2;
  localparam logic [2:0] PM_SPACE = 3'd3;
  localparam logic [2:0] PM_NONE  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  // codes 4..7 carry no parity slot
  function automatic logic mode_has_parity(input logic [2:0] mode);
    return !mode[2];
  endfunction

endpackage

// File: rtl/uart_par_tx_parity.sv
module uart_par_tx_parity
  import uart_par_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [2:0]        mode_i,
  output logic              par_o
);

  logic ones_odd;
  assign ones_odd = ^data_i;

  always_comb begin
    unique case (mode_i)
      PM_EVEN:  par_o = ones_odd;
      PM_ODD:   par_o = !ones_odd;
      PM_MARK:  par_o = 1'b1;
      PM_SPACE: par_o = 1'b0;
      default:  par_o = 1'b1;  // no slot is sent, value unused
    endcase
  end

endmodule

// File: rtl/uart_par_tx_bit_timer.sv
module uart_par_tx_bit_timer #(
  parameter int unsigned OS_RATE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_done_o
);

  localparam int unsigned CNT_W = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OS_RATE - 1);

  logic [CNT_W-1:0] cnt_q;

  assign bit_done_o = run_i && tick_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R3: oversampling count never passes the bit length
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);

  // R3: count only moves on a tick
  a_r3_cnt_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/uart_par_tx.sv
module uart_par_tx
  import uart_par_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned OS_RATE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [2:0]        mode_i,
  input  logic              tick_i,
  output logic              tx_o
);

  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shift_q;
  logic [IDX_W-1:0]  idx_q;
  logic              par_q;
  logic              has_par_q;
  logic              par_new;
  logic              bit_done;
  logic              accept;
  logic              busy;

  assign busy    = (state_q != ST_IDLE);
  assign ready_o = !busy;
  assign accept  = valid_i && ready_o;

  uart_par_tx_parity #(.DATA_W(DATA_W)) i_parity (
    .data_i (data_i),
    .mode_i (mode_i),
    .par_o  (par_new)
  );

  uart_par_tx_bit_timer #(.OS_RATE(OS_RATE)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (busy),
    .tick_i     (tick_i),
    .bit_done_o (bit_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shift_q   <= '0;
      idx_q     <= '0;
      par_q     <= 1'b1;
      has_par_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          shift_q   <= data_i;
          par_q     <= par_new;
          has_par_q <= mode_has_parity(mode_i);
          idx_q     <= '0;
          state_q   <= ST_START;
        end
        ST_START: if (bit_done) state_q <= ST_DATA;
        ST_DATA: if (bit_done) begin
          shift_q <= shift_q >> 1;
          if (idx_q == IDX_LAST) state_q <= has_par_q ? ST_PARITY : ST_STOP;
          else idx_q <= idx_q + 1'b1;
        end
        ST_PARITY: if (bit_done) state_q <= ST_STOP;
        ST_STOP:   if (bit_done) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START:  tx_o = 1'b0;
      ST_DATA:   tx_o = shift_q[0];
      ST_PARITY: tx_o = par_q;
      default:   tx_o = 1'b1;
    endcase
  end

  // R1: line is high whenever the block is ready
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> tx_o);

  // R2: acceptance starts a start bit and drops ready
  a_r2_accept_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (!ready_o && !tx_o));

  // R3: the line only changes on a tick while busy
  a_r3_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !tick_i) |=> ($stable(tx_o) && !ready_o));

  // R8: parity slot reached only for modes that carry one
  a_r8_no_parity_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PARITY) |-> has_par_q);

  // R10: frame ends exactly on the stop bit's last tick
  a_r10_ready_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && bit_done) |=> ready_o);

endmodule

// File: tb/test_uart_par_tx.sv
module test_uart_par_tx;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned OS_RATE = 16;
  localparam time         CYCLE   = 4ns;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic              valid_i = 1'b0;
  logic              ready_o;
  logic [2:0]        mode_i = 3'd0;
  logic              tick_i = 1'b0;
  logic              tx_o;

  int checks = 0;
  int errors = 0;
  logic [1:0] div_q = '0;

  always #(CYCLE/2) clk_i = ~clk_i;

  // one tick every third cycle, driven away from the active edge
  always @(negedge clk_i) begin
    div_q  <= (div_q == 2'd2) ? 2'd0 : div_q + 2'd1;
    tick_i <= (div_q == 2'd2);
  end

  uart_par_tx #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) i_uart_par_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .valid_i (valid_i),
    .ready_o (ready_o),
    .mode_i  (mode_i),
    .tick_i  (tick_i),
    .tx_o    (tx_o)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      while (!tick_i) @(posedge clk_i);
    end
    #1;
  endtask

  // Sends one frame and checks every bit slot at mid-bit.
  // mid_* are applied right after acceptance; poke raises valid_i during the frame.
  task automatic send_frame(input logic [DATA_W-1:0] d, input logic [2:0] m,
                            input logic [DATA_W-1:0] mid_d, input logic [2:0] mid_m,
                            input bit poke, input string ptag);
    logic exp_bits [DATA_W+3];
    int   nb;
    nb = 0;
    exp_bits[nb++] = 1'b0;
    for (int i = 0; i < DATA_W; i++) exp_bits[nb++] = d[i];
    case (m)
      3'd0: exp_bits[nb++] = ^d;
      3'd1: exp_bits[nb++] = ~^d;
      3'd2: exp_bits[nb++] = 1'b1;
      3'd3: exp_bits[nb++] = 1'b0;
      default: ;
    endcase
    exp_bits[nb++] = 1'b1;

    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    data_i  = d;
    mode_i  = m;
    valid_i = 1'b1;
    @(posedge clk_i);
    #1;
    valid_i = poke;
    data_i  = mid_d;
    mode_i  = mid_m;
    check("R2", tx_o, 1'b0, "start level after accept");
    check("R2", ready_o, 1'b0, "ready after accept");

    for (int b = 0; b < nb; b++) begin
      string req;
      req = (b == nb - 2 && nb == DATA_W + 3) ? ptag : ((b == nb - 1) ? "R8/R3 stop" : "R3/R9");
      wait_ticks(OS_RATE / 2);
      check(req, tx_o, exp_bits[b], $sformatf("bit %0d of %s frame", b, ptag));
      check("R2", ready_o, 1'b0, "ready mid-frame");
      if (b == nb - 1) begin
        valid_i = 1'b0;
        wait_ticks(OS_RATE / 2 - 1);
        check("R10", ready_o, 1'b0, "ready one tick before frame end");
        wait_ticks(1);
        check("R10", ready_o, 1'b1, "ready after last stop tick");
        check("R1", tx_o, 1'b1, "idle level after frame");
      end else begin
        wait_ticks(OS_RATE / 2);
      end
    end
  endtask

  task automatic t_reset;
    #1;
    check("R1", tx_o, 1'b1, "line during reset");
    check("R1", ready_o, 1'b1, "ready during reset");
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1", tx_o, 1'b1, "line after reset");
    check("R1", ready_o, 1'b1, "ready after reset");
  endtask

  task automatic t_even;
    send_frame(8'h41, 3'd0, 8'h41, 3'd0, 1'b0, "R4 even");
    send_frame(8'h07, 3'd0, 8'h07, 3'd0, 1'b0, "R4 even");
  endtask

  task automatic t_odd;
    send_frame(8'h41, 3'd1, 8'h41, 3'd1, 1'b0, "R5 odd");
    send_frame(8'h00, 3'd1, 8'h00, 3'd1, 1'b0, "R5 odd");
  endtask

  task automatic t_mark_space;
    send_frame(8'h41, 3'd2, 8'h41, 3'd2, 1'b0, "R6 mark");
    send_frame(8'h00, 3'd2, 8'h00, 3'd2, 1'b0, "R6 mark");
    send_frame(8'h41, 3'd3, 8'h41, 3'd3, 1'b0, "R7 space");
    send_frame(8'hFF, 3'd3, 8'hFF, 3'd3, 1'b0, "R7 space");
  endtask

  task automatic t_none;
    send_frame(8'h41, 3'd4, 8'h41, 3'd4, 1'b0, "R8 none");
    send_frame(8'hA5, 3'd7, 8'hA5, 3'd7, 1'b0, "R8 unused code");
  endtask

  task automatic t_capture;
    // R9: inputs swapped and valid raised mid-frame
    send_frame(8'h41, 3'd0, 8'hBE, 3'd2, 1'b1, "R9 captured even");
    send_frame(8'h3C, 3'd4, 8'hC3, 3'd1, 1'b1, "R9 captured none");
  endtask

  task automatic t_back_to_back;
    // R10: second frame is offered as soon as ready returns
    send_frame(8'h55, 3'd1, 8'h55, 3'd1, 1'b0, "R10 first odd");
    send_frame(8'hAA, 3'd0, 8'hAA, 3'd0, 1'b0, "R10 second even");
  endtask

  initial begin
    #(CYCLE * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_even();
    t_odd();
    t_mark_space();
    t_none();
    t_capture();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule